// File: doc/BRIEF.md
# Parallel Two-Stream Decision-Feedback Slicer Loop

This block is the decision loop of a two-output decision-feedback equalizer, unrolled to resolve P symbol periods per clock. Its throughput is P symbols times the clock rate. Each parallel word carries P lanes. Every lane has two feed-forward soft values, one per decision stream (A and B). Lane 0 holds the oldest symbol. Each stream's decision is a single bit, 0 or 1. It is the sign of the stream's soft value plus a feedback term. That term adds one signed coefficient for every set bit among the previous MB decisions of both streams, so each stream's feedback depends on both streams.

The feedback arithmetic never sits inside the loop. In the first pipeline stage, every lane precomputes its candidate decision pair for all 2^(2·MB) possible histories. In the second stage, a lookahead table gives, for each possible incoming history, the history left at the end of the word. The only logic inside the recurrence is one multiplexer that selects from that table. The per-lane outputs are resolved after the loop: the first MB lanes come from the lookahead results, and the remaining lanes are derived incrementally from the decisions of their preceding lanes. The last MB decision pairs are kept as history for the next word.

Top module: `pdfe_loop`

## Requirements
- R1: After reset, out_valid and all decision outputs are 0. The decision history is all zeros, so the first word behaves as if every earlier decision were 0.
- R2: The decision for a stream is 1 when its soft value plus its feedback term is greater than or equal to zero, and 0 otherwise. A sum of exactly 0 gives 1 and a sum of -1 gives 0.
- R3: A word presented with in_valid high at a rising edge appears on dec_a/dec_b with out_valid high exactly two rising edges later.
- R4: Lane k occupies bits [k*W +: W] of soft_a and soft_b, and bit k of dec_a and dec_b. Lane 0 is the oldest symbol. Lane k's feedback uses the decisions of lanes k-1 down to k-MB of the same word.
- R5: The first lanes of a word take their feedback history from the last MB decision pairs of the previous valid word. The decision at delay m (m=0 most recent) uses coefficient index ((o*2)+s)*MB+m, a CW-bit signed field of coef. Here o is the output stream (0=A, 1=B) and s is the source stream of that earlier decision.
- R6: Cycles with in_valid low leave the history unchanged and produce out_valid low two edges later. The soft values presented during those cycles have no effect.
- R7: Each stream's feedback includes the earlier decisions of the other stream through the cross coefficients (o≠s).
- R8: For any sequence of valid words, the outputs equal bit for bit those of a serial one-symbol-at-a-time decision loop run over the same symbols in lane order.
- R9: While out_valid is high, the held history equals the decision pairs of the last MB lanes on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A parallel word is present on soft_a/soft_b |
| soft_a | input | P*W | Stream A feed-forward soft values, lane k at [k*W +: W], signed |
| soft_b | input | P*W | Stream B feed-forward soft values, lane k at [k*W +: W], signed |
| coef | input | 4*MB*CW | Feedback coefficients, field ((o*2)+s)*MB+m, signed, held static while words are in flight |
| out_valid | output | 1 | dec_a/dec_b carry a resolved word |
| dec_a | output | P | Stream A decisions, bit k for lane k |
| dec_b | output | P | Stream B decisions, bit k for lane k |

## Verification
With all coefficients at zero, the decisions reduce to plain sign slicing. That tests lane order and the threshold at 0 and -1 without interference from the feedback. A single nonzero cross coefficient, with soft values held near the threshold, shows whether stream A's decisions from earlier lanes, and from the tail of the previous word, reach stream B. Long random runs with random coefficients and random idle gaps are compared against a serial loop model. Those runs separate a correct carry of history across words and bubbles from history corrupted by idle cycles or taken from the wrong lanes.

// File: rtl/pdfe_loop.sv
module pdfe_loop #(
  parameter int P  = 4,
  parameter int MB = 2,
  parameter int W  = 8,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [P*W-1:0]    soft_a,
  input  logic [P*W-1:0]    soft_b,
  input  logic [4*MB*CW-1:0] coef,
  output logic              out_valid,
  output logic [P-1:0]      dec_a,
  output logic [P-1:0]      dec_b
);
  localparam int HW = 2 * MB;
  localparam int NH = 1 << HW;
  localparam int MX = (W > CW) ? W : CW;
  localparam int SW = MX + $clog2(2 * MB + 1) + 1;
  localparam int NL = (MB < P) ? MB : P;

  logic [1:0]    cand_c [P][NH];
  logic [1:0]    cand_r [P][NH];
  logic          v_r;
  logic [HW-1:0] hist;
  logic [HW-1:0] fin   [NH];
  logic [1:0]    la    [NH][NL];
  logic [1:0]    dec_c [P];
  logic [HW-1:0] hist_exp;

  function automatic logic [CW-1:0] cf(input int o, input int s, input int m);
    return coef[(((o * 2) + s) * MB + m) * CW +: CW];
  endfunction

  function automatic logic [1:0] slice(input logic [W-1:0] ya, input logic [W-1:0] yb,
                                       input logic [HW-1:0] h);
    logic signed [SW-1:0] sa, sb;
    sa = SW'($signed(ya));
    sb = SW'($signed(yb));
    for (int m = 0; m < MB; m++) begin
      if (h[2*m]) begin
        sa = sa + SW'($signed(cf(0, 0, m)));
        sb = sb + SW'($signed(cf(1, 0, m)));
      end
      if (h[2*m+1]) begin
        sa = sa + SW'($signed(cf(0, 1, m)));
        sb = sb + SW'($signed(cf(1, 1, m)));
      end
    end
    return {~sb[SW-1], ~sa[SW-1]};
  endfunction

  always_comb begin
    for (int k = 0; k < P; k++)
      for (int h = 0; h < NH; h++)
        cand_c[k][h] = slice(soft_a[k*W +: W], soft_b[k*W +: W], HW'(h));
  end

  always_ff @(posedge clk) begin
    if (in_valid)
      for (int k = 0; k < P; k++)
        for (int h = 0; h < NH; h++)
          cand_r[k][h] <= cand_c[k][h];
  end

  always_comb begin
    logic [HW-1:0] hv;
    logic [1:0]    d;
    for (int h = 0; h < NH; h++) begin
      hv = HW'(h);
      for (int k = 0; k < P; k++) begin
        d = cand_r[k][hv];
        if (k < NL) la[h][k] = d;
        hv = (hv << 2) | HW'(d);
      end
      fin[h] = hv;
    end
  end

  always_comb begin
    logic [HW-1:0] hv;
    hv = hist;
    for (int k = 0; k < P; k++) begin
      if (k < NL) dec_c[k] = la[hist][k];
      else        dec_c[k] = cand_r[k][hv];
      hv = (hv << 2) | HW'(dec_c[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_r       <= 1'b0;
      out_valid <= 1'b0;
      hist      <= '0;
      dec_a     <= '0;
      dec_b     <= '0;
    end else begin
      v_r       <= in_valid;
      out_valid <= v_r;
      if (v_r) begin
        hist <= fin[hist];
        for (int k = 0; k < P; k++) begin
          dec_a[k] <= dec_c[k][0];
          dec_b[k] <= dec_c[k][1];
        end
      end
    end
  end

  always_comb begin
    hist_exp = '0;
    for (int m = 0; m < NL; m++) begin
      hist_exp[2*m]   = dec_a[P-1-m];
      hist_exp[2*m+1] = dec_b[P-1-m];
    end
  end

  AST_HIST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (hist == hist_exp)); // R9
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !v_r |=> $stable(hist)); // R6
  AST_STAGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v_r); // R3
  AST_STAGE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    v_r |=> out_valid); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !v_r |=> !out_valid); // R6
endmodule

// File: tb/pdfe_loop_tb_top.sv
module pdfe_loop_tb_top;
  localparam int P = 4, MB = 2, W = 8, CW = 8;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [P*W-1:0] soft_a = '0, soft_b = '0;
  logic [4*MB*CW-1:0] coef = '0;
  logic out_valid;
  logic [P-1:0] dec_a, dec_b;

  pdfe_loop #(.P(P), .MB(MB), .W(W), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .soft_a(soft_a), .soft_b(soft_b),
    .coef(coef), .out_valid(out_valid), .dec_a(dec_a), .dec_b(dec_b));

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  int ha[MB], hb[MB];
  int cf[2][2][MB];
  logic [P-1:0] q_a[$], q_b[$];
  int q_cyc[$];
  string q_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_coef();
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < MB; m++)
          coef[(((o*2)+s)*MB+m)*CW +: CW] = CW'(cf[o][s][m]);
  endtask

  task automatic clear_hist();
    for (int m = 0; m < MB; m++) begin ha[m] = 0; hb[m] = 0; end
  endtask

  task automatic model_word(input logic [P*W-1:0] sa, input logic [P*W-1:0] sb,
                            output logic [P-1:0] ea, output logic [P-1:0] eb);
    for (int k = 0; k < P; k++) begin
      int ua, ub;
      ua = $signed(sa[k*W +: W]);
      ub = $signed(sb[k*W +: W]);
      for (int m = 0; m < MB; m++) begin
        if (ha[m] != 0) begin ua += cf[0][0][m]; ub += cf[1][0][m]; end
        if (hb[m] != 0) begin ua += cf[0][1][m]; ub += cf[1][1][m]; end
      end
      ea[k] = (ua >= 0);
      eb[k] = (ub >= 0);
      for (int m = MB-1; m > 0; m--) begin ha[m] = ha[m-1]; hb[m] = hb[m-1]; end
      ha[0] = ea[k];
      hb[0] = eb[k];
    end
  endtask

  task automatic send(input logic [P*W-1:0] sa, input logic [P*W-1:0] sb, input string req);
    logic [P-1:0] ea, eb;
    @(negedge clk);
    soft_a = sa; soft_b = sb; in_valid = 1;
    model_word(sa, sb, ea, eb);
    q_a.push_back(ea); q_b.push_back(eb); q_cyc.push_back(cyc); q_req.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      soft_a = P*W'($urandom); soft_b = P*W'($urandom);
    end
  endtask

  function automatic logic [P*W-1:0] rnd_word();
    logic [P*W-1:0] v;
    for (int k = 0; k < P; k++) v[k*W +: W] = W'($urandom_range(0, 255));
    return v;
  endfunction

  function automatic logic [P*W-1:0] fill(input int v);
    logic [P*W-1:0] r;
    for (int k = 0; k < P; k++) r[k*W +: W] = W'(v);
    return r;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (q_cyc.size() > 0 && q_cyc[0] + 2 == cyc) begin
        logic [P-1:0] ea, eb;
        string r;
        ea = q_a.pop_front(); eb = q_b.pop_front(); r = q_req.pop_front();
        void'(q_cyc.pop_front());
        chk(out_valid === 1'b1, "R3", "out_valid", int'(out_valid), 1);
        chk(dec_a === ea, r, "dec_a", int'(dec_a), int'(ea));
        chk(dec_b === eb, r, "dec_b", int'(dec_b), int'(eb));
      end else begin
        chk(out_valid === 1'b0, "R6", "out_valid idle", int'(out_valid), 0);
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [P*W-1:0] sa, sb;
    for (int o = 0; o < 2; o++) for (int s = 0; s < 2; s++) for (int m = 0; m < MB; m++) cf[o][s][m] = 0;
    clear_hist();
    load_coef();
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(dec_a === '0 && dec_b === '0, "R1", "decisions in reset", int'({dec_b, dec_a}), 0);
    // R1: first word after reset relies on zero history with large feedback
    cf[0][0][0] = -100; cf[1][1][1] = -100;
    load_coef();
    @(negedge clk); rst_n = 1;
    sa = fill(10); sb = fill(10);
    send(sa, sb, "R1");
    idle(4);
    // R2 threshold with zero coefficients: lanes 0, -1, 127, -128
    for (int o = 0; o < 2; o++) for (int s = 0; s < 2; s++) for (int m = 0; m < MB; m++) cf[o][s][m] = 0;
    load_coef();
    sa = {8'h80, 8'h7F, 8'hFF, 8'h00};
    sb = {8'h00, 8'hFF, 8'h00, 8'hFF};
    send(sa, sb, "R2");
    // R4 lane order: distinct patterns
    send({8'h01, 8'hF0, 8'hF0, 8'h05}, {8'hF0, 8'h01, 8'hF0, 8'h02}, "R4");
    send({8'hFE, 8'hFE, 8'h03, 8'h03}, {8'h03, 8'hFE, 8'h03, 8'hFE}, "R4");
    idle(4);
    // R7 cross coupling: B pushed negative by earlier A decisions
    cf[1][0][0] = -20;
    load_coef();
    send(fill(5), fill(10), "R7");
    send({8'hFB, 8'h05, 8'hFB, 8'h05}, fill(10), "R7");
    send({8'h05, 8'hFB, 8'hFB, 8'hFB}, fill(10), "R7");
    idle(4);
    // R4 / R5 intra-word and cross-word history with delay-2 taps
    cf[1][0][0] = 0; cf[0][0][1] = -30; cf[1][1][1] = -30; cf[0][1][0] = 15;
    load_coef();
    send(fill(20), fill(20), "R5");
    send(fill(20), fill(20), "R5");
    send({8'h10, 8'hF0, 8'h10, 8'h1E}, {8'hF0, 8'h10, 8'h1E, 8'h1E}, "R4");
    send(fill(20), fill(20), "R5");
    // R6 bubbles with garbage between words
    idle(3);
    send(fill(20), fill(20), "R6");
    idle(1);
    send(fill(25), fill(5), "R6");
    idle(4);
    // R8 random equivalence, random coefficients and gaps
    for (int run = 0; run < 6; run++) begin
      for (int o = 0; o < 2; o++) for (int s = 0; s < 2; s++) for (int m = 0; m < MB; m++)
        cf[o][s][m] = $urandom_range(0, 160) - 80;
      load_coef();
      for (int i = 0; i < 150; i++) begin
        sa = rnd_word(); sb = rnd_word();
        send(sa, sb, "R8");
        if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
      end
      idle(4);
    end
    idle(4);
    chk(q_cyc.size() == 0, "R3", "pending words", q_cyc.size(), 0);
    finish_run();
  end
endmodule